// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns the peripheral clock into the timing strobes a UART needs. It emits a one-cycle sample tick at sixteen times the bit rate, which the receiver and the transmitter share. It also emits a bit strobe on every sixteenth sample tick. The rate is set by a divider register that counts in quarter-clock steps. The register holds an integer part and a two-bit fraction, so the spacing between ticks is (4 + DIV)/4 clocks on average. The resulting bit rate is 4·fclk / (16·(4 + DIV)).

Software writes the divider as a 32-bit word. The divider field sits in bits 20:6, and bit 6 carries a weight of one quarter of a clock. The six lowest bits and everything above the field are ignored and read back as zero. A phase accumulator in quarter-clock units adds four on every enabled clock. When the phase reaches the modulus 4 + DIV, the modulus is subtracted and a tick is emitted. This keeps the average tick period exact with no drift.

Writing the divider restarts both the phase and the count of sixteen. Dropping both the receive enable and the transmit enable holds the generator idle and cleared.

Top module: `fbaud_gen`

## Requirements
- R1: After reset, sample_tick and bit_tick are low and div_rdata reads zero.
- R2: A write stores wr_data bits 20:6 as the divider DIV. div_rdata returns exactly those bits in place, with bits 5:0 and 31:21 reading zero whatever value was written there.
- R3: With DIV = 0, sample_tick is high on every enabled clock, giving a bit rate of fclk/16.
- R4: Let the k-th enabled clock edge after a restart be counted from k = 1. sample_tick is high after edge k exactly when floor(4k/(4+DIV)) differs from floor(4(k-1)/(4+DIV)).
- R5: bit_tick is high only together with sample_tick, on the 16th, 32nd, 48th and later sample ticks after a restart.
- R6: The edge that captures a write clears the phase and the tick count, and both strobes are low after it. Counting for R4 and R5 starts again at the next edge, using the new divider.
- R7: While rx_en and tx_en are both low, both strobes stay low and the phase and count are cleared. Either enable alone is enough to run the generator, and counting restarts from k = 1.
- R8: The largest DIV of 32767 gives the slowest rate, about fclk/(16·8192). Its first sample tick follows edge k = 8193.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Divider register write strobe |
| wr_data | input | 32 | Divider register write value |
| div_rdata | output | 32 | Divider register readback |
| rx_en | input | 1 | Receiver enabled |
| tx_en | input | 1 | Transmitter enabled |
| sample_tick | output | 1 | One-cycle 16x oversampling strobe |
| bit_tick | output | 1 | One-cycle strobe every 16 sample ticks |

## Verification
Several groups of divider values are applied, each run compared edge by edge with the floor(4k/(4+DIV)) rule.
- A DIV of zero checks the every-clock case.
- Random small divisors with non-zero fraction bits separate the quarter-step accumulator from a plain integer divider.
- Divisors that are multiples of four check integer periods.
- The largest divisor checks that the phase width holds the slowest rate without wrapping.

Each write is made with random values in the ignored bits, which shows whether the readback masks them. Consecutive writes issued mid-run, and enable drop-outs with each enable alone, show whether a restart truly clears the phase and the count of sixteen.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;
  // Pair of strobes produced by the generator each clock.
  typedef struct packed {
    logic sample;
    logic bit_end;
  } fbaud_strobe_t;
endpackage

// File: rtl/bgen_divreg.sv
module bgen_divreg #(
  parameter int REG_W   = 32,
  parameter int REG_LSB = 6,
  parameter int DIV_W   = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic [REG_W-1:0] rd_data
);
  localparam int TOP_W = REG_W - REG_LSB - DIV_W;

  always_ff @(posedge clk) begin
    if (rst)        div_q <= '0;
    else if (wr_en) div_q <= wr_data[REG_LSB +: DIV_W];
  end

  // Readback: field in place, everything else zero.
  generate
    if (REG_LSB > 0 && TOP_W > 0) begin : g_both
      assign rd_data = {{TOP_W{1'b0}}, div_q, {REG_LSB{1'b0}}};
    end else if (REG_LSB > 0) begin : g_low
      assign rd_data = {div_q, {REG_LSB{1'b0}}};
    end else if (TOP_W > 0) begin : g_high
      assign rd_data = {{TOP_W{1'b0}}, div_q};
    end else begin : g_none
      assign rd_data = div_q;
    end
  endgenerate
endmodule

// File: rtl/bgen_phase.sv
module bgen_phase #(
  parameter int DIV_W     = 15,
  parameter int FRAC_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             hit,
  output logic             tick_q
);
  localparam int ACC_W = DIV_W + FRAC_BITS + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_BITS;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] modulus;

  assign modulus = STEP + ACC_W'(div);
  assign acc_nxt = acc_q + STEP;
  assign hit     = run && !clear && (acc_nxt >= modulus);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (hit) begin
      acc_q  <= acc_nxt - modulus;
      tick_q <= 1'b1;
    end else begin
      acc_q  <= acc_nxt;
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bgen_ovs.sv
module bgen_ovs #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic hit,
  output logic bit_q
);
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  generate
    if ((1 << CNT_W) == OVS) begin : g_pow2
      assign cnt_inc = cnt_q + 1'b1;
    end else begin : g_mod
      assign cnt_inc = wrap ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= cnt_inc;
      bit_q <= wrap;
    end else begin
      bit_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fbaud_gen.sv
module fbaud_gen #(
  parameter int REG_W     = 32,
  parameter int REG_LSB   = 6,
  parameter int DIV_W     = 15,
  parameter int FRAC_BITS = 2,
  parameter int OVS       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] div_rdata,
  input  logic             rx_en,
  input  logic             tx_en,
  output logic             sample_tick,
  output logic             bit_tick
);
  import fbaud_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic             run;
  logic             hit;
  fbaud_strobe_t    strobe;

  assign run = rx_en | tx_en;

  bgen_divreg #(.REG_W(REG_W), .REG_LSB(REG_LSB), .DIV_W(DIV_W)) i_divreg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .div_q(div_q), .rd_data(div_rdata)
  );

  bgen_phase #(.DIV_W(DIV_W), .FRAC_BITS(FRAC_BITS)) i_phase (
    .clk(clk), .rst(rst), .clear(wr_en), .run(run), .div(div_q),
    .hit(hit), .tick_q(strobe.sample)
  );

  bgen_ovs #(.OVS(OVS)) i_ovs (
    .clk(clk), .rst(rst), .clear(wr_en), .run(run), .hit(hit),
    .bit_q(strobe.bit_end)
  );

  assign sample_tick = strobe.sample;
  assign bit_tick    = strobe.bit_end;
endmodule

// File: rtl/fbaud_gen_chk.sv
module fbaud_gen_chk #(
  parameter int REG_W   = 32,
  parameter int REG_LSB = 6,
  parameter int DIV_W   = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] div_rdata,
  input logic             rx_en,
  input logic             tx_en,
  input logic             sample_tick,
  input logic             bit_tick
);
  // R1: strobes low after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sample_tick && !bit_tick));

  // R2: readback holds still unless written
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(div_rdata));

  // R2: ignored low bits read as zero
  a_r2_low_zero: assert property (@(posedge clk) disable iff (rst)
    div_rdata[REG_LSB-1:0] == '0);

  // R3: zero divider ticks on every enabled clock
  a_r3_every_clock: assert property (@(posedge clk) disable iff (rst)
    (div_rdata[REG_LSB +: DIV_W] == '0 && (rx_en || tx_en) && !wr_en)
      |=> sample_tick);

  // R5: bit strobe only with a sample strobe
  a_r5_bit_with_sample: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  // R6: a write edge leaves both strobes low
  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!sample_tick && !bit_tick));

  // R7: idle when both enables are low
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !tx_en) |=> (!sample_tick && !bit_tick));
endmodule

bind fbaud_gen fbaud_gen_chk #(.REG_W(REG_W), .REG_LSB(REG_LSB), .DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .div_rdata(div_rdata),
  .rx_en(rx_en), .tx_en(tx_en), .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/test_fbaud_gen.sv
module test_fbaud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] div_rdata;
  logic        rx_en = 1'b0;
  logic        tx_en = 1'b0;
  logic        sample_tick;
  logic        bit_tick;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fbaud_gen i_fbaud_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .div_rdata(div_rdata), .rx_en(rx_en), .tx_en(tx_en),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  function automatic longint ticks_after(input longint k, input longint dv);
    return (4 * k) / (4 + dv);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare strobes for edges k0..k0+n-1 after a restart
  task automatic follow(input longint dv, input int n, input string req);
    for (int k = 1; k <= n; k++) begin
      longint a = ticks_after(k, dv);
      longint b = ticks_after(k - 1, dv);
      bit es = (a != b);
      bit eb = ((a / 16) != (b / 16));
      @(posedge clk); #2;
      chk(sample_tick == es, {req, "/R4 sample"}, sample_tick, es);
      chk(bit_tick == eb, {req, "/R5 bit"}, bit_tick, eb);
    end
  endtask

  // Write a divider with junk in the ignored bits, then follow it
  task automatic run_div(input int unsigned dv, input int n);
    logic [31:0] d;
    d = ($urandom() & ~(32'h7FFF << 6)) | ((dv & 32'h7FFF) << 6);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
    chk(!sample_tick && !bit_tick, "R6 write clears", {sample_tick, bit_tick}, 0);
    chk(div_rdata == ((dv & 32'h7FFF) << 6), "R2 readback", div_rdata, (dv & 32'h7FFF) << 6);
    follow(dv, n, "R6");
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #2;
    chk(!sample_tick && !bit_tick, "R1 strobes", {sample_tick, bit_tick}, 0);
    chk(div_rdata == 0, "R1 readback", div_rdata, 0);
    @(negedge clk); rst = 1'b0; rx_en = 1'b1; tx_en = 1'b1;

    // R2: all ones written, only the field reads back
    @(negedge clk); wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(posedge clk); #2; wr_en = 1'b0;
    chk(div_rdata == 32'h001F_FFC0, "R2 mask", div_rdata, 32'h001F_FFC0);

    // R3: zero divider, every clock, bit every 16
    run_div(0, 64);
    // integer periods and fractional ones
    run_div(4, 90);
    run_div(1, 90);
    run_div(7, 120);
    for (int i = 0; i < 30; i++) run_div($urandom_range(0, 40), 150);

    // R7: idle with both enables low, then each alone
    run_div(3, 20);
    @(negedge clk); rx_en = 1'b0; tx_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #2;
      chk(!sample_tick && !bit_tick, "R7 idle", {sample_tick, bit_tick}, 0);
    end
    chk(div_rdata == (32'd3 << 6), "R7 divider kept", div_rdata, 32'd3 << 6);
    @(negedge clk); rx_en = 1'b1;
    follow(3, 120, "R7 rx only");
    @(negedge clk); rx_en = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); tx_en = 1'b1;
    follow(3, 120, "R7 tx only");

    // R8: slowest divider, first tick after edge 8193
    run_div(32767, 8200);
    chk(1'b1, "R8 slow run", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule